// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Pulse Generator

This block is a clocked replacement for one half of a dual monostable multivibrator. Instead of an external resistor and capacitor, a cycle count on the `width` input sets how long the output pulse lasts. Three input edges can start a pulse, and each one is gated by the levels of the other two inputs. The first is a falling edge on `a_in`. The second is a rising edge on `b_in`. The third is the active-low clear input `clr_n_in` returning high.

A qualified trigger that arrives while a pulse is running restarts the full width from that trigger, so the pulse grows longer. Pulling `clr_n_in` low forces the output back to standby in the same cycle and cancels the pulse. When a pulse runs to its end without being cancelled, a one-cycle `done` strobe follows it. For a dual part, instantiate the block twice.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A falling edge on `a_in` starts a pulse only while `b_in` is high and `clr_n_in` is high.
- R2: A rising edge on `b_in` starts a pulse only while `a_in` is low and `clr_n_in` is high.
- R3: A rising edge on `clr_n_in` starts a pulse when `a_in` is low and `b_in` is high in the same sample.
- R4: While `clr_n_in` is low, `q` is 0 and `qn` is 1 in the same cycle. The running pulse is cancelled and no trigger is accepted. A clear sampled in the same cycle as a trigger edge wins.
- R5: `qn` is always the complement of `q`. In standby `q` is 0.
- R6: The inputs pass through one sampling register. An edge seen between two samples raises `q` in the cycle after the second sample. `q` then stays high for exactly `width` cycles after the last qualified trigger, and a retrigger restarts this count.
- R7: Static input levels never start a pulse. While `a_in` stays high or `b_in` stays low with no edge, `q` stays 0 unless a pulse is already running.
- R8: A `width` value of 0 is treated as 1.
- R9: `done` is high for exactly one cycle, in the first cycle after a pulse that ran to its end. It stays low when the pulse is cancelled by the clear.
- R10: A synchronous active-low `rst_n` empties the counter and the stored samples and puts the outputs in standby (`q`=0, `qn`=1, `done`=0). The first sample taken after reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 1 | Trigger input, fires on a falling edge |
| b_in | input | 1 | Trigger input, fires on a rising edge |
| clr_n_in | input | 1 | Clear, active low; its rising edge can also trigger |
| width | input | CNT_W | Pulse length in clock cycles (0 is taken as 1) |
| q | output | 1 | Pulse output |
| qn | output | 1 | Complement of `q` |
| done | output | 1 | One-cycle strobe after a pulse that ended on its own |

## Verification
The bench builds the block with the default `CNT_W` of 8. It drives `width` values from 0 to 6, so widths of one and two cycles are reached. With such short widths, a retrigger in the final cycle, a new pulse right after a `done`, and a clear landing on the last high cycle all occur many times in a few thousand cycles. Directed phases cover each gated trigger path, as well as the clear abort and the zero-width case.

// File: rtl/oneshot_pkg.sv
// Shared types for the one-shot pulse generator.
// Assumes: nothing beyond a single clock domain.
package oneshot_pkg;

    // One flag per input transition the qualifier can act on.
    typedef struct packed {
        logic fall_a;
        logic rise_b;
        logic rise_clr;
    } edges_t;

endpackage

// File: rtl/os_input_edges.sv
// Samples the three trigger inputs once per clock and reports transitions
// between the two most recent samples.
// Assumes: inputs are already synchronous to clk (no metastability stage here).
module os_input_edges
    import oneshot_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   a_in,
    input  logic   b_in,
    input  logic   clr_n_in,
    output logic   a_smp,
    output logic   b_smp,
    output logic   clr_smp,
    output edges_t edg
);

    logic a_prv, b_prv, clr_prv;
    logic smp_valid, prv_valid;

    // Two-deep sample history with a validity flag per stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_smp     <= 1'b0;
            b_smp     <= 1'b0;
            clr_smp   <= 1'b0;
            a_prv     <= 1'b0;
            b_prv     <= 1'b0;
            clr_prv   <= 1'b0;
            smp_valid <= 1'b0;
            prv_valid <= 1'b0;
        end else begin
            a_smp     <= a_in;
            b_smp     <= b_in;
            clr_smp   <= clr_n_in;
            a_prv     <= a_smp;
            b_prv     <= b_smp;
            clr_prv   <= clr_smp;
            smp_valid <= 1'b1;
            prv_valid <= smp_valid;
        end
    end

    // Edge flags; suppressed until two valid samples exist.
    always_comb begin
        edg.fall_a   = prv_valid &  a_prv   & ~a_smp;
        edg.rise_b   = prv_valid & ~b_prv   &  b_smp;
        edg.rise_clr = prv_valid & ~clr_prv &  clr_smp;
    end

endmodule

// File: rtl/os_trig_qual.sv
// Gates each detected edge with the sampled levels of the other inputs
// and produces a single load request plus the clear abort.
// Assumes: levels and edges come from the same sample stage.
module os_trig_qual
    import oneshot_pkg::*;
(
    input  edges_t edg,
    input  logic   a_smp,
    input  logic   b_smp,
    input  logic   clr_smp,
    output logic   trig,
    output logic   abort
);

    logic via_a, via_b, via_clr;

    // Qualification of each path; clear low blocks all of them.
    always_comb begin
        via_a   = edg.fall_a   &  b_smp;
        via_b   = edg.rise_b   & ~a_smp;
        via_clr = edg.rise_clr & ~a_smp & b_smp;
        trig    = clr_smp & (via_a | via_b | via_clr);
        abort   = ~clr_smp;
    end

endmodule

// File: rtl/os_pulse_timer.sv
// Down-counter that holds the pulse active for a loaded number of cycles
// and emits a strobe when it expires without being aborted.
// Assumes: load and abort are never high together (qualifier guarantees it).
module os_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] width,
    input  logic             load,
    input  logic             abort,
    input  logic             clr_now,
    output logic             active,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] width_eff;

    // Zero width is promoted to a single cycle.
    always_comb width_eff = (width == '0) ? ONE : width;

    // Count update: reload on trigger, empty on clear, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= (cnt == ONE) & ~load & ~abort & clr_now;
            if (load)
                cnt <= width_eff;
            else if (abort)
                cnt <= '0;
            else if (cnt != '0)
                cnt <= cnt - ONE;
        end
    end

    // Pulse is running while the counter is non-zero.
    always_comb active = (cnt != '0);

    // R4: a clear with no reload empties the counter on the next edge.
    p_abort_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !load) |=> (cnt == '0));

    // R6: every reload leaves the pulse running.
    p_load_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);

    // R9: the strobe never lasts two cycles.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the strobe follows the last counted cycle.
    p_done_from_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cnt) == ONE));

endmodule

// File: rtl/oneshot_pulse_gen.sv
// Retriggerable one-shot: three gated trigger edges, clear abort, and a
// programmable pulse width in clock cycles. One channel of a dual part.
// Assumes: inputs synchronous to clk; clr_n_in masks q combinationally.
module oneshot_pulse_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    input  logic             clr_n_in,
    input  logic [CNT_W-1:0] width,
    output logic             q,
    output logic             qn,
    output logic             done
);

    import oneshot_pkg::*;

    logic   a_smp, b_smp, clr_smp;
    edges_t edg;
    logic   trig, abort, active;

    os_input_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (a_in),
        .b_in     (b_in),
        .clr_n_in (clr_n_in),
        .a_smp    (a_smp),
        .b_smp    (b_smp),
        .clr_smp  (clr_smp),
        .edg      (edg)
    );

    os_trig_qual u_qual (
        .edg     (edg),
        .a_smp   (a_smp),
        .b_smp   (b_smp),
        .clr_smp (clr_smp),
        .trig    (trig),
        .abort   (abort)
    );

    os_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .width   (width),
        .load    (trig),
        .abort   (abort),
        .clr_now (clr_n_in),
        .active  (active),
        .done    (done)
    );

    // Output stage: the live clear level masks the pulse without waiting.
    always_comb begin
        q  = active & clr_n_in;
        qn = ~q;
    end

    // R4: no trigger is accepted while the sampled clear is low.
    p_clear_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_smp |-> !trig);

    // R9: no strobe while the clear input is low.
    p_done_not_aborted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_in |=> !done);

endmodule

// File: tb/oneshot_pulse_gen_tb.sv
module oneshot_pulse_gen_tb;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a_in = 1'b1;
    logic             b_in = 1'b0;
    logic             clr_n_in = 1'b1;
    logic [CNT_W-1:0] width = 8'd4;
    logic             q, qn, done;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    string tag = "R10";

    // Reference state, kept from the requirements.
    bit m_sa, m_sb, m_sc, m_pa, m_pb, m_pc, m_sv, m_pv, m_done;
    int m_cnt;

    always #5 clk = ~clk;

    oneshot_pulse_gen #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .clr_n_in(clr_n_in), .width(width), .q(q), .qn(qn), .done(done)
    );

    function automatic bit exp_trig(bit pv, bit pa, bit sa, bit pb, bit sb, bit pc, bit sc);
        bit r1_path, r2_path, r3_path;
        r1_path = pv && pa && !sa && sb;
        r2_path = pv && !pb && sb && !sa;
        r3_path = pv && !pc && sc && !sa && sb;
        return sc && (r1_path || r2_path || r3_path);
    endfunction

    function automatic int eff_width(logic [CNT_W-1:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_sa, m_sb, m_sc, m_pa, m_pb, m_pc, m_sv, m_pv, m_done} = '0;
            m_cnt = 0;
        end else begin
            bit t;
            t = exp_trig(m_pv, m_pa, m_sa, m_pb, m_sb, m_pc, m_sc);
            m_done = (m_cnt == 1) && !t && m_sc && clr_n_in;
            if (t) m_cnt = eff_width(width);
            else if (!m_sc) m_cnt = 0;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            m_pa = m_sa; m_pb = m_sb; m_pc = m_sc; m_pv = m_sv;
            m_sa = a_in; m_sb = b_in; m_sc = clr_n_in; m_sv = 1'b1;
        end
    end

    task automatic check_now(string t);
        bit eq;
        eq = (m_cnt != 0) && clr_n_in;
        n_checks++;
        if (q !== eq || qn !== !eq || done !== m_done) begin
            n_errors++;
            $display("FAIL %s: q=%b qn=%b done=%b expected q=%b qn=%b done=%b at %0t",
                     t, q, qn, done, eq, !eq, m_done, $time);
        end
    endtask

    // Compare every cycle, away from the clock edge.
    always @(posedge clk) begin
        #2;
        if (!finished) check_now(tag);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        int hi_len;
        void'($urandom(32'd1357));
        // R10: reset state, then the first sample must not look like an edge.
        step(3);
        rst_n = 1'b1;
        a_in = 1'b0; b_in = 1'b1;
        step(6);
        // R7: static levels with no edge.
        tag = "R7";
        a_in = 1'b1; b_in = 1'b1;
        step(8);
        // R1: falling A with B high, width 4; count the high cycles.
        tag = "R1";
        width = 8'd4;
        a_in = 1'b0;
        hi_len = 0;
        repeat (10) begin
            @(posedge clk); #3;
            if (q) hi_len++;
        end
        n_checks++;
        if (hi_len != 4) begin
            n_errors++;
            $display("FAIL R6: pulse length %0d expected %0d", hi_len, 4);
        end
        @(negedge clk);
        // R1: falling A while B low must not fire.
        a_in = 1'b1; b_in = 1'b0; step(3);
        a_in = 1'b0; step(6);
        // R2: rising B with A low.
        tag = "R2";
        b_in = 1'b1; step(3);
        // R6: retrigger mid-pulse by toggling B.
        tag = "R6";
        width = 8'd5;
        b_in = 1'b0; step(1); b_in = 1'b1; step(9);
        // R4: clear mid-pulse; immediate standby, no strobe.
        tag = "R4";
        b_in = 1'b0; step(1); b_in = 1'b1; step(2);
        clr_n_in = 1'b0;
        #1;
        n_checks++;
        if (q !== 1'b0 || qn !== 1'b1) begin
            n_errors++;
            $display("FAIL R4: q=%b qn=%b expected q=0 qn=1", q, qn);
        end
        // R4: trigger edge while clear held low.
        @(negedge clk); b_in = 1'b0; step(1); b_in = 1'b1; step(4);
        // R3: clear release with A low and B high fires.
        tag = "R3";
        clr_n_in = 1'b1; step(8);
        // R8: zero width acts as one cycle.
        tag = "R8";
        width = 8'd0;
        b_in = 1'b0; step(1); b_in = 1'b1; step(5);
        // R9/R5: constrained random mix.
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(3) == 0) a_in = ~a_in;
            if ($urandom_range(3) == 0) b_in = ~b_in;
            if (clr_n_in) begin
                if ($urandom_range(15) == 0) clr_n_in = 1'b0;
            end else if ($urandom_range(1) == 0) clr_n_in = 1'b1;
            if ($urandom_range(7) == 0) width = CNT_W'($urandom_range(6));
            if (i == 2000) tag = "R5";
            step(1);
        end
        // R10: reset mid-activity returns to standby.
        tag = "R10";
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; step(3);
        summary();
    end

endmodule